// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

This block issues the multi-write command sequences that byte-wide parallel NOR flash devices need before they program, erase or report their identity. A host pulses `start` with an operation code, an address-convention select and (for sector or block erase) a target address. The block then plays out the matching list of bus cycles on a simple strobe-based master port, one cycle at a time. Each bus cycle is a single-clock write or read strobe followed by one idle clock. The physical bus timing and any programming data buffer belong to neighbouring logic.

Every command write aimed at one of the two fixed unlock locations has that location ANDed with a mask picked by `mask_sel`, so that devices with fewer decoded address lines are served. Erase writes can be spaced by a settle wait. The identification sequence has longer waits on mode entry and exit, and `zero_timing` removes all of these waits. After an erase command the block pulses `poll_start` to a completion poller, which runs in slow mode. It reports `done` only once `poll_done` has come back.

The identification (probe) operation first resets the device, with an optional two-write unlock prefix, and then enters ID mode. It reads the manufacturer and device codes. When either code is the continuation value 0x7F it reads one extra byte for it. It then leaves ID mode. The captured codes are compared against expected values, and the manufacturer code is checked for odd parity.

Top module: `flash_cmd_seq`

## Requirements
- R1: Every write strobe (`bus_we`) and read strobe (`bus_re`) is high for exactly one clock, the two are never high together, and neither is high while `busy` is low.
- R2: Writes to the first unlock location use address 0x5555 & M and writes to the second use 0x2AAA & M, where M is 0xFFFF for `mask_sel`=0, 0x07FF for 1 and 0x0FFF for 2. The sector or block target address is used unmasked.
- R3: A `start` with `mask_sel`=3, or with `op` greater than 4, produces no bus cycle and gives a one-clock `done` with `cfg_err`=1. A valid `start` clears `cfg_err`.
- R4: `op`=1 (program setup) writes, in order, 0xAA to the first unlock location, 0x55 to the second, and 0xA0 to the first. It never pulses `poll_start`.
- R5: `op`=2, 3 and 4 (sector, block, chip erase) each write 0xAA, 0x55 and 0x80, and then 0xAA and 0x55 again, to the unlock locations (first, second, first, first, second). The sixth and last write is 0x30 to the target for `op`=2, 0x50 to the target for `op`=3, and 0x10 to the first unlock location for `op`=4.
- R6: Consecutive erase write strobes are GAP_CYC+3 clocks apart, or 3 clocks apart when `zero_timing`=1.
- R7: After the final erase write the block pulses `poll_start` once for one clock. `done` rises only after `poll_done` has been seen.
- R8: `op`=0 (probe) writes a reset, an ID entry and a second reset. The reset is an optional 0xAA/0x55 prefix (present when `long_reset`=1) followed by 0xF0 to the first unlock location. The ID entry is 0xAA, 0x55 and 0x90 to the unlock locations.
- R9: The probe reads offset 0 (manufacturer) and then offset 1 (device). Offset 0x100 is read if the manufacturer byte was 0x7F, and offset 0x101 if the device byte was 0x7F. A continued code is {first byte, extra byte}; otherwise the code is {0x00, byte}.
- R10: After a probe, `parity_warn` is 1 exactly when the low byte of `mfr_id` has an even number of set bits.
- R11: After a probe, `id_match` is 1 exactly when `mfr_id`==`exp_mfr` and `dev_id`==`exp_dev`.
- R12: The first ID read strobe comes ENTER_CYC+3 clocks after the 0x90 write strobe, or 3 clocks after it when `zero_timing`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse to begin an operation (ignored while busy) |
| op | input | 3 | 0 probe, 1 program setup, 2 sector erase, 3 block erase, 4 chip erase |
| mask_sel | input | 2 | Unlock address mask: 0 full, 1 11-bit, 2 12-bit, 3 invalid |
| target_addr | input | ADDR_W | Sector or block address for erase |
| long_reset | input | 1 | Precede each probe reset with the unlock prefix |
| zero_timing | input | 1 | Skip all settle and mode waits |
| exp_mfr | input | 16 | Expected manufacturer code |
| exp_dev | input | 16 | Expected device code |
| bus_addr | output | ADDR_W | Bus cycle address |
| bus_wdata | output | 8 | Bus write data |
| bus_we | output | 1 | One-clock write strobe |
| bus_re | output | 1 | One-clock read strobe |
| bus_rdata | input | 8 | Read data, valid while `bus_re` is high |
| poll_start | output | 1 | One-clock request to the slow completion poller |
| poll_done | input | 1 | Poller finished |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-clock end-of-operation pulse |
| cfg_err | output | 1 | Last start was rejected |
| mfr_id | output | 16 | Captured manufacturer code |
| dev_id | output | 16 | Captured device code |
| parity_warn | output | 1 | Manufacturer byte lacks odd parity |
| id_match | output | 1 | Both codes equal the expected values |

## Verification
Program setup and all three erase kinds are run under every legal mask. This separates the 0x5555/0x2AAA masking from the unmasked target address, and the three erase final bytes from one another. Probes mix `long_reset` on and off with ID bytes that are plain, 0x7F on one side only, or 0x7F on both sides. This tells a missing or surplus continuation read apart from a wrong byte order. The ID values also vary in parity and in whether they equal the expected codes. Each sequence is run with and without `zero_timing`, and with several poller delays, so that skipped waits, a wrong gap length and a `done` that arrives before `poll_done` each show up as a measured cycle difference.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    typedef enum logic [2:0] {
        OP_PROBE  = 3'd0,
        OP_PROG   = 3'd1,
        OP_SECTOR = 3'd2,
        OP_BLOCK  = 3'd3,
        OP_CHIP   = 3'd4
    } op_e;

    typedef enum logic [3:0] {
        K_SKIP, K_WR, K_RD_MFR, K_RD_DEV, K_RD_MFR_X, K_RD_DEV_X,
        K_GAP, K_ENTER, K_EXIT, K_POLL, K_END
    } kind_e;

    typedef enum logic [1:0] {A_UNLK1, A_UNLK2, A_TARGET, A_NONE} asel_e;

    typedef enum logic [2:0] {ST_IDLE, ST_RUN, ST_STROBE, ST_WAIT, ST_POLL} state_e;

    typedef struct packed {
        kind_e      kind;
        asel_e      asel;
        logic [7:0] data;
    } step_t;

    localparam int STEP_W = 5;

    localparam logic [15:0] UNLK1_ADDR = 16'h5555;
    localparam logic [15:0] UNLK2_ADDR = 16'h2AAA;
    localparam logic [15:0] OFS_MFR    = 16'h0000;
    localparam logic [15:0] OFS_DEV    = 16'h0001;
    localparam logic [15:0] OFS_MFR_X  = 16'h0100;
    localparam logic [15:0] OFS_DEV_X  = 16'h0101;

    localparam logic [7:0] D_KEY1   = 8'hAA;
    localparam logic [7:0] D_KEY2   = 8'h55;
    localparam logic [7:0] D_PROG   = 8'hA0;
    localparam logic [7:0] D_ERASE  = 8'h80;
    localparam logic [7:0] D_SECT   = 8'h30;
    localparam logic [7:0] D_BLK    = 8'h50;
    localparam logic [7:0] D_CHIP   = 8'h10;
    localparam logic [7:0] D_IDENT  = 8'h90;
    localparam logic [7:0] D_RESET  = 8'hF0;
    localparam logic [7:0] ID_CONT  = 8'h7F;

    function automatic step_t mk(kind_e k, asel_e a, logic [7:0] d);
        step_t s;
        s.kind = k;
        s.asel = a;
        s.data = d;
        return s;
    endfunction

    function automatic logic sel_valid(logic [1:0] sel);
        return sel != 2'd3;
    endfunction

    function automatic logic [15:0] sel_mask(logic [1:0] sel);
        case (sel)
            2'd0:    return 16'hFFFF;
            2'd1:    return 16'h07FF;
            2'd2:    return 16'h0FFF;
            default: return 16'h0000;
        endcase
    endfunction

    function automatic logic op_valid(logic [2:0] op);
        return op <= 3'd4;
    endfunction

    function automatic logic odd_par(logic [7:0] b);
        return ^b;
    endfunction

    // Optional unlock pair that precedes a probe reset write.
    function automatic step_t reset_prefix(logic [1:0] j, logic lr);
        if (!lr) return mk(K_SKIP, A_NONE, 8'h00);
        case (j)
            2'd0:    return mk(K_WR, A_UNLK1, D_KEY1);
            2'd2:    return mk(K_WR, A_UNLK2, D_KEY2);
            default: return mk(K_GAP, A_NONE, 8'h00);
        endcase
    endfunction

    function automatic step_t step_at(logic [2:0] op, logic [STEP_W-1:0] idx, logic lr);
        step_t s;
        step_t fin;
        s = mk(K_END, A_NONE, 8'h00);
        if (op == OP_PROBE) begin
            case (idx)
                5'd0:                      s = mk(K_ENTER, A_NONE, 8'h00);
                5'd1, 5'd2, 5'd3, 5'd4:    s = reset_prefix(2'(idx - 5'd1), lr);
                5'd5:                      s = mk(K_WR, A_UNLK1, D_RESET);
                5'd6:                      s = mk(K_EXIT, A_NONE, 8'h00);
                5'd7:                      s = mk(K_WR, A_UNLK1, D_KEY1);
                5'd8:                      s = mk(K_GAP, A_NONE, 8'h00);
                5'd9:                      s = mk(K_WR, A_UNLK2, D_KEY2);
                5'd10:                     s = mk(K_GAP, A_NONE, 8'h00);
                5'd11:                     s = mk(K_WR, A_UNLK1, D_IDENT);
                5'd12:                     s = mk(K_ENTER, A_NONE, 8'h00);
                5'd13:                     s = mk(K_RD_MFR, A_NONE, 8'h00);
                5'd14:                     s = mk(K_RD_DEV, A_NONE, 8'h00);
                5'd15:                     s = mk(K_RD_MFR_X, A_NONE, 8'h00);
                5'd16:                     s = mk(K_RD_DEV_X, A_NONE, 8'h00);
                5'd17, 5'd18, 5'd19, 5'd20: s = reset_prefix(2'(idx - 5'd17), lr);
                5'd21:                     s = mk(K_WR, A_UNLK1, D_RESET);
                5'd22:                     s = mk(K_EXIT, A_NONE, 8'h00);
                default:                   s = mk(K_END, A_NONE, 8'h00);
            endcase
        end else if (op == OP_PROG) begin
            case (idx)
                5'd0:    s = mk(K_WR, A_UNLK1, D_KEY1);
                5'd1:    s = mk(K_WR, A_UNLK2, D_KEY2);
                5'd2:    s = mk(K_WR, A_UNLK1, D_PROG);
                default: s = mk(K_END, A_NONE, 8'h00);
            endcase
        end else begin
            if (op == OP_SECTOR)     fin = mk(K_WR, A_TARGET, D_SECT);
            else if (op == OP_BLOCK) fin = mk(K_WR, A_TARGET, D_BLK);
            else                     fin = mk(K_WR, A_UNLK1, D_CHIP);
            case (idx)
                5'd0, 5'd6: s = mk(K_WR, A_UNLK1, D_KEY1);
                5'd2, 5'd8: s = mk(K_WR, A_UNLK2, D_KEY2);
                5'd4:       s = mk(K_WR, A_UNLK1, D_ERASE);
                5'd10:      s = fin;
                5'd1, 5'd3, 5'd5, 5'd7, 5'd9, 5'd11: s = mk(K_GAP, A_NONE, 8'h00);
                5'd12:      s = mk(K_POLL, A_NONE, 8'h00);
                default:    s = mk(K_END, A_NONE, 8'h00);
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/flash_gap_timer.sv
module flash_gap_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] len,
    output logic             fire
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (load)        cnt <= len;
        else if (cnt != '0)   cnt <= cnt - CNT_W'(1);
    end

    assign fire = (cnt == CNT_W'(1));

    // R6: a wait ends in a single expiry pulse
    assert_fire_single_R6: assert property (@(posedge clk) disable iff (rst)
        (fire && !load) |=> !fire);

endmodule

// File: rtl/flash_id_capture.sv
module flash_id_capture
    import flash_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        clr,
    input  logic        cap_en,
    input  kind_e       cap_kind,
    input  logic [7:0]  rdata,
    input  logic        fin,
    input  logic [15:0] exp_mfr,
    input  logic [15:0] exp_dev,
    output logic [15:0] mfr_id,
    output logic [15:0] dev_id,
    output logic        mfr_cont,
    output logic        dev_cont,
    output logic        parity_warn,
    output logic        id_match
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            mfr_id      <= '0;
            dev_id      <= '0;
            parity_warn <= 1'b0;
            id_match    <= 1'b0;
        end else begin
            if (cap_en) begin
                case (cap_kind)
                    K_RD_MFR:   mfr_id <= {8'h00, rdata};
                    K_RD_DEV:   dev_id <= {8'h00, rdata};
                    K_RD_MFR_X: mfr_id <= {mfr_id[7:0], rdata};
                    K_RD_DEV_X: dev_id <= {dev_id[7:0], rdata};
                    default:    ;
                endcase
            end
            if (fin) begin
                parity_warn <= !odd_par(mfr_id[7:0]);
                id_match    <= (mfr_id == exp_mfr) && (dev_id == exp_dev);
            end
        end
    end

    // A code extends only while it still holds a single 0x7F byte.
    assign mfr_cont = (mfr_id[15:8] == 8'h00) && (mfr_id[7:0] == ID_CONT);
    assign dev_cont = (dev_id[15:8] == 8'h00) && (dev_id[7:0] == ID_CONT);

    // R9: extra ID reads are only issued behind a continuation byte
    assert_mfr_ext_gate_R9: assert property (@(posedge clk) disable iff (rst)
        (cap_en && cap_kind == K_RD_MFR_X) |-> mfr_cont);
    assert_dev_ext_gate_R9: assert property (@(posedge clk) disable iff (rst)
        (cap_en && cap_kind == K_RD_DEV_X) |-> dev_cont);

endmodule

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W    = 18,
    parameter int CNT_W     = 8,
    parameter int GAP_CYC   = 5,
    parameter int ENTER_CYC = 9,
    parameter int EXIT_CYC  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [2:0]        op,
    input  logic [1:0]        mask_sel,
    input  logic [ADDR_W-1:0] target_addr,
    input  logic              long_reset,
    input  logic              zero_timing,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [7:0]        bus_wdata,
    output logic              bus_we,
    output logic              bus_re,
    output logic              poll_start,
    input  logic              poll_done,
    output logic              busy,
    output logic              done,
    output logic              cfg_err,
    output logic              tmr_load,
    output logic [CNT_W-1:0]  tmr_len,
    input  logic              tmr_fire,
    output logic              cap_clr,
    output logic              cap_en,
    output kind_e             cap_kind,
    output logic              fin_probe,
    input  logic              mfr_cont,
    input  logic              dev_cont
);
    state_e            st;
    logic [STEP_W-1:0] idx;
    logic [2:0]        op_q;
    logic [15:0]       mask_q;
    logic [ADDR_W-1:0] tgt_q;
    logic              long_q;
    logic              zero_q;
    kind_e             rd_kind_q;

    step_t             cur;
    logic [ADDR_W-1:0] wr_addr;
    logic [ADDR_W-1:0] rd_addr;
    logic              is_wait;
    logic              rd_skip;
    logic              start_ok;

    always_comb begin
        cur = step_at(op_q, idx, long_q);

        case (cur.asel)
            A_UNLK1:  wr_addr = ADDR_W'(UNLK1_ADDR & mask_q);
            A_UNLK2:  wr_addr = ADDR_W'(UNLK2_ADDR & mask_q);
            A_TARGET: wr_addr = tgt_q;
            default:  wr_addr = '0;
        endcase

        case (cur.kind)
            K_RD_MFR:   rd_addr = ADDR_W'(OFS_MFR);
            K_RD_DEV:   rd_addr = ADDR_W'(OFS_DEV);
            K_RD_MFR_X: rd_addr = ADDR_W'(OFS_MFR_X);
            default:    rd_addr = ADDR_W'(OFS_DEV_X);
        endcase

        is_wait = (cur.kind == K_GAP) || (cur.kind == K_ENTER) || (cur.kind == K_EXIT);
        if (zero_q)                   tmr_len = '0;
        else if (cur.kind == K_ENTER) tmr_len = CNT_W'(ENTER_CYC);
        else if (cur.kind == K_EXIT)  tmr_len = CNT_W'(EXIT_CYC);
        else                          tmr_len = CNT_W'(GAP_CYC);

        rd_skip  = ((cur.kind == K_RD_MFR_X) && !mfr_cont) ||
                   ((cur.kind == K_RD_DEV_X) && !dev_cont);
        start_ok = sel_valid(mask_sel) && op_valid(op);
    end

    assign tmr_load  = (st == ST_RUN) && is_wait && (tmr_len != '0);
    assign cap_clr   = (st == ST_IDLE) && start && start_ok;
    assign cap_en    = (st == ST_STROBE) && bus_re;
    assign cap_kind  = rd_kind_q;
    assign fin_probe = (st == ST_RUN) && (cur.kind == K_END) && (op_q == OP_PROBE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            idx        <= '0;
            op_q       <= '0;
            mask_q     <= '0;
            tgt_q      <= '0;
            long_q     <= 1'b0;
            zero_q     <= 1'b0;
            rd_kind_q  <= K_SKIP;
            bus_addr   <= '0;
            bus_wdata  <= '0;
            bus_we     <= 1'b0;
            bus_re     <= 1'b0;
            poll_start <= 1'b0;
            busy       <= 1'b0;
            done       <= 1'b0;
            cfg_err    <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        if (!start_ok) begin
                            done    <= 1'b1;
                            cfg_err <= 1'b1;
                        end else begin
                            op_q    <= op;
                            mask_q  <= sel_mask(mask_sel);
                            tgt_q   <= target_addr;
                            long_q  <= long_reset;
                            zero_q  <= zero_timing;
                            idx     <= '0;
                            busy    <= 1'b1;
                            cfg_err <= 1'b0;
                            st      <= ST_RUN;
                        end
                    end
                end
                ST_RUN: begin
                    case (cur.kind)
                        K_WR: begin
                            bus_addr  <= wr_addr;
                            bus_wdata <= cur.data;
                            bus_we    <= 1'b1;
                            st        <= ST_STROBE;
                        end
                        K_RD_MFR, K_RD_DEV, K_RD_MFR_X, K_RD_DEV_X: begin
                            if (rd_skip) begin
                                idx <= idx + STEP_W'(1);
                            end else begin
                                bus_addr  <= rd_addr;
                                bus_re    <= 1'b1;
                                rd_kind_q <= cur.kind;
                                st        <= ST_STROBE;
                            end
                        end
                        K_GAP, K_ENTER, K_EXIT: begin
                            if (tmr_len == '0) idx <= idx + STEP_W'(1);
                            else               st  <= ST_WAIT;
                        end
                        K_POLL: begin
                            poll_start <= 1'b1;
                            st         <= ST_POLL;
                        end
                        K_END: begin
                            done <= 1'b1;
                            busy <= 1'b0;
                            st   <= ST_IDLE;
                        end
                        default: idx <= idx + STEP_W'(1);
                    endcase
                end
                ST_STROBE: begin
                    bus_we <= 1'b0;
                    bus_re <= 1'b0;
                    idx    <= idx + STEP_W'(1);
                    st     <= ST_RUN;
                end
                ST_WAIT: begin
                    if (tmr_fire) begin
                        idx <= idx + STEP_W'(1);
                        st  <= ST_RUN;
                    end
                end
                ST_POLL: begin
                    poll_start <= 1'b0;
                    if (poll_done) begin
                        idx <= idx + STEP_W'(1);
                        st  <= ST_RUN;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R1: strobes are single-clock, exclusive and only inside an operation
    assert_we_width_R1: assert property (@(posedge clk) disable iff (rst)
        bus_we |=> !bus_we);
    assert_re_width_R1: assert property (@(posedge clk) disable iff (rst)
        bus_re |=> !bus_re);
    assert_strobe_excl_R1: assert property (@(posedge clk) disable iff (rst)
        !(bus_we && bus_re));
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!bus_we && !bus_re));
    // R3: a rejected start answers at once with an error and stays idle
    assert_reject_R3: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && start && !start_ok) |=> (done && cfg_err && !busy));
    // R7: poller request is a pulse and completion waits for the poller
    assert_poll_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        poll_start |=> !poll_start);
    assert_done_waits_R7: assert property (@(posedge clk) disable iff (rst)
        (st == ST_POLL && !poll_done) |=> !done);

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W    = 18,
    parameter int GAP_CYC   = 1250,
    parameter int ENTER_CYC = 1250000,
    parameter int EXIT_CYC  = 5000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [2:0]        op,
    input  logic [1:0]        mask_sel,
    input  logic [ADDR_W-1:0] target_addr,
    input  logic              long_reset,
    input  logic              zero_timing,
    input  logic [15:0]       exp_mfr,
    input  logic [15:0]       exp_dev,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [7:0]        bus_wdata,
    output logic              bus_we,
    output logic              bus_re,
    input  logic [7:0]        bus_rdata,
    output logic              poll_start,
    input  logic              poll_done,
    output logic              busy,
    output logic              done,
    output logic              cfg_err,
    output logic [15:0]       mfr_id,
    output logic [15:0]       dev_id,
    output logic              parity_warn,
    output logic              id_match
);
    localparam int MAX_A    = (GAP_CYC > EXIT_CYC) ? GAP_CYC : EXIT_CYC;
    localparam int MAX_WAIT = (ENTER_CYC > MAX_A) ? ENTER_CYC : MAX_A;
    localparam int CNT_W    = $clog2(MAX_WAIT + 1) + 1;

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_len;
    logic             tmr_fire;
    logic             cap_clr;
    logic             cap_en;
    kind_e            cap_kind;
    logic             fin_probe;
    logic             mfr_cont;
    logic             dev_cont;

    flash_seq_ctrl #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W), .GAP_CYC(GAP_CYC),
        .ENTER_CYC(ENTER_CYC), .EXIT_CYC(EXIT_CYC)
    ) ctrl_i (
        .clk(clk), .rst(rst), .start(start), .op(op), .mask_sel(mask_sel),
        .target_addr(target_addr), .long_reset(long_reset), .zero_timing(zero_timing),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re),
        .poll_start(poll_start), .poll_done(poll_done), .busy(busy), .done(done),
        .cfg_err(cfg_err), .tmr_load(tmr_load), .tmr_len(tmr_len), .tmr_fire(tmr_fire),
        .cap_clr(cap_clr), .cap_en(cap_en), .cap_kind(cap_kind), .fin_probe(fin_probe),
        .mfr_cont(mfr_cont), .dev_cont(dev_cont)
    );

    flash_gap_timer #(.CNT_W(CNT_W)) timer_i (
        .clk(clk), .rst(rst), .load(tmr_load), .len(tmr_len), .fire(tmr_fire)
    );

    flash_id_capture cap_i (
        .clk(clk), .rst(rst), .clr(cap_clr), .cap_en(cap_en), .cap_kind(cap_kind),
        .rdata(bus_rdata), .fin(fin_probe), .exp_mfr(exp_mfr), .exp_dev(exp_dev),
        .mfr_id(mfr_id), .dev_id(dev_id), .mfr_cont(mfr_cont), .dev_cont(dev_cont),
        .parity_warn(parity_warn), .id_match(id_match)
    );

endmodule

// File: tb/flash_cmd_seq_tb.sv
module flash_cmd_seq_tb_top;
    localparam int AW  = 18;
    localparam int GAP = 5;
    localparam int ENT = 9;
    localparam int EXT = 4;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst, start, long_reset, zero_timing;
    logic [2:0]    op;
    logic [1:0]    mask_sel;
    logic [AW-1:0] target_addr;
    logic [15:0]   exp_mfr, exp_dev;
    logic [AW-1:0] bus_addr;
    logic [7:0]    bus_wdata, bus_rdata;
    logic          bus_we, bus_re, poll_start, busy, done, cfg_err, parity_warn, id_match;
    logic          poll_done = 1'b0;
    logic [15:0]   mfr_id, dev_id;

    flash_cmd_seq #(.ADDR_W(AW), .GAP_CYC(GAP), .ENTER_CYC(ENT), .EXIT_CYC(EXT)) dut_i (
        .clk(clk), .rst(rst), .start(start), .op(op), .mask_sel(mask_sel),
        .target_addr(target_addr), .long_reset(long_reset), .zero_timing(zero_timing),
        .exp_mfr(exp_mfr), .exp_dev(exp_dev), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata), .poll_start(poll_start),
        .poll_done(poll_done), .busy(busy), .done(done), .cfg_err(cfg_err),
        .mfr_id(mfr_id), .dev_id(dev_id), .parity_warn(parity_warn), .id_match(id_match)
    );

    // Device model: ID bytes at the four identification offsets.
    logic [7:0] m0, m1, d0, d1;
    assign bus_rdata = !bus_re                ? 8'h00 :
                       (bus_addr == AW'(0))     ? m0 :
                       (bus_addr == AW'(1))     ? d0 :
                       (bus_addr == AW'('h100)) ? m1 :
                       (bus_addr == AW'('h101)) ? d1 : 8'hFF;

    int n_chk = 0, n_fail = 0;
    int cyc = 0, wn = 0, rn = 0, pseen = 0, pend = 0, pdelay = 1, pcyc = 0, pdcyc = 0;
    int dcyc = 0, strobe_bad = 0;
    logic          prev_we = 1'b0, prev_re = 1'b0;
    logic [AW-1:0] wa [0:31];
    logic [7:0]    wd [0:31];
    int            wc [0:31];
    logic [AW-1:0] ra [0:7];
    int            rc [0:7];

    always @(negedge clk) begin
        cyc++;
        if (bus_we && wn < 32) begin wa[wn] = bus_addr; wd[wn] = bus_wdata; wc[wn] = cyc; wn++; end
        if (bus_re && rn < 8)  begin ra[rn] = bus_addr; rc[rn] = cyc; rn++; end
        if ((bus_we && prev_we) || (bus_re && prev_re) || (bus_we && bus_re) ||
            (!busy && (bus_we || bus_re)))
            strobe_bad++;
        prev_we = bus_we;
        prev_re = bus_re;
        poll_done = 1'b0;
        if (pend > 0) begin
            pend--;
            if (pend == 0) begin poll_done = 1'b1; pdcyc = cyc; end
        end
        if (poll_start) begin pseen++; pcyc = cyc; pend = pdelay; end
    end

    task automatic check(bit ok, string tag, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [15:0] mask_of(int s);
        return (s == 0) ? 16'hFFFF : (s == 1) ? 16'h07FF : 16'h0FFF;
    endfunction

    logic [AW-1:0] ea [0:31];
    logic [7:0]    ed [0:31];
    int            en;

    task automatic add_w(logic [AW-1:0] a, logic [7:0] d);
        ea[en] = a; ed[en] = d; en++;
    endtask

    task automatic build_exp(int o, int ms, logic [AW-1:0] tgt, bit lr);
        logic [AW-1:0] u1, u2;
        u1 = AW'(16'h5555 & mask_of(ms));
        u2 = AW'(16'h2AAA & mask_of(ms));
        en = 0;
        if (o == 1) begin
            add_w(u1, 8'hAA); add_w(u2, 8'h55); add_w(u1, 8'hA0);
        end else if (o >= 2) begin
            add_w(u1, 8'hAA); add_w(u2, 8'h55); add_w(u1, 8'h80);
            add_w(u1, 8'hAA); add_w(u2, 8'h55);
            if (o == 2)      add_w(tgt, 8'h30);
            else if (o == 3) add_w(tgt, 8'h50);
            else             add_w(u1, 8'h10);
        end else begin
            if (lr) begin add_w(u1, 8'hAA); add_w(u2, 8'h55); end
            add_w(u1, 8'hF0);
            add_w(u1, 8'hAA); add_w(u2, 8'h55); add_w(u1, 8'h90);
            if (lr) begin add_w(u1, 8'hAA); add_w(u2, 8'h55); end
            add_w(u1, 8'hF0);
        end
    endtask

    task automatic run_op(int o, int ms, logic [AW-1:0] tgt, bit lr, bit zt);
        int t;
        @(negedge clk);
        op = 3'(o); mask_sel = 2'(ms); target_addr = tgt; long_reset = lr; zero_timing = zt;
        wn = 0; rn = 0; pseen = 0; pcyc = 0; pdcyc = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        t = 0;
        while (!done && t < 20000) begin @(negedge clk); t++; end
        if (!done) check(0, "R1", "operation timeout", t, 0);
        dcyc = cyc;
    endtask

    task automatic verify_op(int o, int ms, logic [AW-1:0] tgt, bit lr, bit zt, bit want_match);
        logic [15:0] em, edv;
        bit ok;
        int i90, gap_exp;
        string tag;
        em  = (m0 == 8'h7F) ? {m0, m1} : {8'h00, m0};
        edv = (d0 == 8'h7F) ? {d0, d1} : {8'h00, d0};
        exp_mfr = want_match ? em  : (em ^ 16'h0004);
        exp_dev = want_match ? edv : edv;
        pdelay = 1 + int'($urandom % 6);
        build_exp(o, ms, tgt, lr);
        run_op(o, ms, tgt, lr, zt);
        if (ms == 3 || o > 4) begin
            check(cfg_err == 1'b1, "R3", "cfg_err on rejected start", cfg_err, 1);
            check(wn == 0 && rn == 0, "R3", "bus cycles on rejected start", wn + rn, 0);
            return;
        end
        check(cfg_err == 1'b0, "R3", "cfg_err on valid start", cfg_err, 0);
        tag = (o == 0) ? "R8 R2" : (o == 1) ? "R4 R2" : "R5 R2";
        ok = (wn == en);
        for (int i = 0; i < en && ok; i++)
            if (wa[i] !== ea[i] || wd[i] !== ed[i]) begin
                ok = 0;
                check(0, tag, $sformatf("write %0d addr/data", i), {wa[i], wd[i]}, {ea[i], ed[i]});
            end
        if (wn != en) check(0, tag, "write count", wn, en);
        else if (ok)  check(1, tag, "write sequence", 0, 0);
        if (o == 1) check(pseen == 0, "R4", "poll pulses", pseen, 0);
        if (o >= 2) begin
            gap_exp = zt ? 3 : GAP + 3;
            ok = 1;
            for (int i = 1; i < wn; i++) if (wc[i] - wc[i-1] != gap_exp) ok = 0;
            check(ok, "R6", "erase write spacing", (wn > 1) ? wc[1] - wc[0] : 0, gap_exp);
            check(pseen == 1, "R7", "poll pulse count", pseen, 1);
            check(wn > 0 && pcyc > wc[wn-1], "R7", "poll after last write", pcyc, (wn > 0) ? wc[wn-1] : 0);
            check(pdcyc > 0 && dcyc > pdcyc, "R7", "done after poll_done", dcyc, pdcyc);
        end
        if (o == 0) begin
            int ern;
            logic [AW-1:0] er [0:3];
            ern = 0;
            er[ern] = AW'(0); ern++;
            er[ern] = AW'(1); ern++;
            if (m0 == 8'h7F) begin er[ern] = AW'('h100); ern++; end
            if (d0 == 8'h7F) begin er[ern] = AW'('h101); ern++; end
            ok = (rn == ern);
            for (int i = 0; i < ern && ok; i++) if (ra[i] !== er[i]) ok = 0;
            check(ok, "R9", "ID read addresses", rn, ern);
            check(mfr_id == em, "R9", "mfr_id", mfr_id, em);
            check(dev_id == edv, "R9", "dev_id", dev_id, edv);
            check(parity_warn == !(^em[7:0]), "R10", "parity_warn", parity_warn, !(^em[7:0]));
            check(id_match == want_match, "R11", "id_match", id_match, want_match);
            i90 = lr ? 5 : 3;
            check(rn > 0 && wn > i90 && rc[0] - wc[i90] == (zt ? 3 : ENT + 3), "R12",
                  "entry wait", (rn > 0 && wn > i90) ? rc[0] - wc[i90] : -1, zt ? 3 : ENT + 3);
        end
        check(strobe_bad == 0, "R1", "strobe shape", strobe_bad, 0);
    endtask

    function automatic logic [7:0] rnd_id();
        return ($urandom % 4 == 0) ? 8'h7F : 8'($urandom % 127);
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        check(0, "R1", "watchdog expired", cyc, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'h1F2E3D4C));
        rst = 1'b1; start = 1'b0; op = '0; mask_sel = '0; target_addr = '0;
        long_reset = 1'b0; zero_timing = 1'b0; exp_mfr = '0; exp_dev = '0;
        m0 = 8'h01; d0 = 8'h02; m1 = 8'h00; d1 = 8'h00;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !bus_we && !bus_re && !done && !poll_start && !cfg_err, "R1",
              "reset state", {busy, bus_we, bus_re, done, poll_start, cfg_err}, 0);

        // Program setup under every mask (R4, R2)
        for (int ms = 0; ms < 3; ms++) verify_op(1, ms, AW'('h3ABCD), 0, 0, 1);
        // Each erase kind, with and without settle waits (R5, R6, R7)
        verify_op(2, 0, AW'('h2F000), 0, 0, 1);
        verify_op(3, 1, AW'('h31234), 0, 0, 1);
        verify_op(4, 2, AW'('h00000), 0, 1, 1);
        verify_op(2, 2, AW'('h1FFFF), 0, 1, 1);
        // Rejected selections (R3)
        verify_op(2, 3, AW'(0), 0, 0, 1);
        verify_op(6, 0, AW'(0), 0, 0, 1);
        // Probes: plain, one-sided and two-sided continuation (R8..R12)
        m0 = 8'h1F; d0 = 8'h45;                           verify_op(0, 0, AW'(0), 0, 0, 1);
        m0 = 8'h7F; m1 = 8'h9D; d0 = 8'h22;               verify_op(0, 1, AW'(0), 1, 0, 1);
        m0 = 8'h0E; d0 = 8'h7F; d1 = 8'h38;               verify_op(0, 2, AW'(0), 1, 1, 0);
        m0 = 8'h7F; m1 = 8'h7F; d0 = 8'h7F; d1 = 8'hC1;   verify_op(0, 0, AW'(0), 0, 1, 1);
        m0 = 8'h03; d0 = 8'h00;                           verify_op(0, 1, AW'(0), 0, 0, 1);

        for (int n = 0; n < 30; n++) begin
            int o, ms;
            o  = int'($urandom % 5);
            ms = int'($urandom % 3);
            m0 = rnd_id(); m1 = 8'($urandom); d0 = rnd_id(); d1 = 8'($urandom);
            verify_op(o, ms, AW'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule